// File: doc/BRIEF.md
# Signalling-Channel Takeover Sequencer

This block shares the 16 kb/s signalling (D) channel between the terminals on the subscriber bus and a local adapter controller that has its own HDLC formatter. While no local call is in progress, the terminals own the channel, and their upstream D bits go straight through to the network side. The echo path back to the terminals is enabled.

When the local controller raises a request, the block blocks the echo path. Any terminal that is transmitting then sees its own D bit differ from the echo bit, and it backs off as it would after a collision. The block then holds the upstream D line at one for a guard interval of 1.5 ms, counted as 24 strobes of the D-bit rate. If a terminal was cut off in the middle of a frame, the network therefore sees an abort pattern. Only after the guard does the block grant the channel and select the local formatter as the upstream source.

A done pulse from the local side gives the channel back to the terminals. A programmable hold-off interval then keeps a new local grant from starting, so the terminals have time to exchange messages with the network. A request that arrives while the block is busy is remembered and is served once the block is idle again.

Top module: `dchan_takeover`

## Requirements
- R1: While idle (busy low), up_d equals term_d, echo_pass is 1, grant is 0 and local_sel is 0, whatever the value of local_d.
- R2: A request pulse seen while idle makes busy 1 and echo_pass 0 from the next clock cycle on.
- R3: During the guard interval (busy 1, echo_pass 0, grant 0), up_d is 1 whatever the values of term_d and local_d.
- R4: grant rises exactly after GUARD_BITS bit strobes have been counted in the guard interval. GUARD_BITS is the guard time multiplied by the bit rate, rounded up, which gives 24 for the defaults of 1500 us and 16000 b/s.
- R5: While grant is 1, up_d equals local_d, local_sel is 1 and echo_pass stays 0.
- R6: A done pulse while grant is 1 makes grant 0, echo_pass 1 and up_d equal to term_d from the next cycle on.
- R7: After release, busy stays 1 for holdoff_cfg bit strobes, and no grant can start in that time. When holdoff_cfg is 0, busy falls one cycle after release.
- R8: A request pulse that arrives while busy is held. A new takeover (echo_pass 0) starts no later than the second cycle after busy falls.
- R9: A done pulse while grant is 0 has no effect. In idle, echo_pass stays 1. In the guard interval, the guard still runs its full length.
- R10: After reset, busy, grant and local_sel are 0 and echo_pass is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe per D-bit period |
| req | input | 1 | Local access request pulse |
| done | input | 1 | Local message complete pulse |
| holdoff_cfg | input | HOLD_W | Hold-off length after release, in bit strobes |
| term_d | input | 1 | Upstream D bit from the terminals |
| local_d | input | 1 | Upstream D bit from the local formatter |
| up_d | output | 1 | Upstream D bit toward the network |
| echo_pass | output | 1 | Echo path control, 1 = echo enabled, 0 = blocked |
| local_sel | output | 1 | 1 when the local formatter sources upstream D |
| grant | output | 1 | Channel granted to the local side |
| busy | output | 1 | Sequencer not idle |

## Verification
The bench counts the strobes in the guard interval while it toggles term_d. A guard that is off by one strobe, or a guard during which terminal zeros leak upstream, shows up as a wrong count or as a zero on up_d. The release path is checked for an immediate return of the echo path and a correct hold-off length, including a hold-off of zero, where a design that compares too late would stay busy for a whole wrap of the counter. Done pulses outside the grant and requests that arrive while busy are also applied. A design that ended the guard early, or that dropped the held request, would either grant too soon or never start the second takeover.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GUARD = 2'd1,
    ST_OWN   = 2'd2,
    ST_HOLD  = 2'd3
  } dct_state_e;

  // Guard length in bit periods, rounded up.
  function automatic int guard_bits(input int guard_us, input int bit_rate);
    return (guard_us * bit_rate + 999999) / 1000000;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stb,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (stb && (cnt != {CW{1'b1}}))
      cnt <= cnt + 1'b1;
  end

  assign expire = (cnt >= limit);
endmodule

// File: rtl/dct_fsm.sv
module dct_fsm
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       done,
  input  logic       cnt_expire,
  output dct_state_e state,
  output logic       cnt_clr,
  output logic       start_evt,
  output logic       release_evt
);
  dct_state_e nxt;
  logic       req_pend;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req || req_pend) nxt = ST_GUARD;
      ST_GUARD: if (cnt_expire)      nxt = ST_OWN;
      ST_OWN:   if (done)            nxt = ST_HOLD;
      ST_HOLD:  if (cnt_expire)      nxt = ST_IDLE;
      default:                       nxt = ST_IDLE;
    endcase
  end

  assign cnt_clr     = (nxt != state);
  assign start_evt   = (state == ST_IDLE) && (nxt == ST_GUARD);
  assign release_evt = (state == ST_OWN)  && (nxt == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (start_evt)
        req_pend <= 1'b0;
      else if (req)
        req_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dct_mux.sv
module dct_mux
  import dct_pkg::*;
(
  input  dct_state_e state,
  input  logic       term_d,
  input  logic       local_d,
  output logic       up_d,
  output logic       echo_pass,
  output logic       local_sel,
  output logic       grant,
  output logic       busy
);
  always_comb begin
    up_d      = term_d;
    echo_pass = 1'b1;
    local_sel = 1'b0;
    grant     = 1'b0;
    unique case (state)
      ST_GUARD: begin
        up_d      = 1'b1;
        echo_pass = 1'b0;
      end
      ST_OWN: begin
        up_d      = local_d;
        echo_pass = 1'b0;
        local_sel = 1'b1;
        grant     = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/dchan_takeover.sv
module dchan_takeover
  import dct_pkg::*;
#(
  parameter int GUARD_US = 1500,
  parameter int BIT_RATE = 16000,
  parameter int HOLD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              req,
  input  logic              done,
  input  logic [HOLD_W-1:0] holdoff_cfg,
  input  logic              term_d,
  input  logic              local_d,
  output logic              up_d,
  output logic              echo_pass,
  output logic              local_sel,
  output logic              grant,
  output logic              busy
);
  localparam int GUARD_BITS = guard_bits(GUARD_US, BIT_RATE);
  localparam int CW         = max_int(HOLD_W, $clog2(GUARD_BITS + 1));

  dct_state_e    state;
  logic          cnt_clr;
  logic          cnt_expire;
  logic          start_evt;
  logic          release_evt;
  logic [CW-1:0] cnt_limit;

  // One counter serves both timed phases; its limit follows the phase.
  assign cnt_limit = (state == ST_GUARD) ? CW'(GUARD_BITS) : CW'(holdoff_cfg);

  dct_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .done        (done),
    .cnt_expire  (cnt_expire),
    .state       (state),
    .cnt_clr     (cnt_clr),
    .start_evt   (start_evt),
    .release_evt (release_evt)
  );

  dct_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .stb    (bit_stb),
    .limit  (cnt_limit),
    .expire (cnt_expire)
  );

  dct_mux u_mux (
    .state     (state),
    .term_d    (term_d),
    .local_d   (local_d),
    .up_d      (up_d),
    .echo_pass (echo_pass),
    .local_sel (local_sel),
    .grant     (grant),
    .busy      (busy)
  );
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int GUARD_BITS = 24
) (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic req,
  input logic done,
  input logic term_d,
  input logic local_d,
  input logic up_d,
  input logic echo_pass,
  input logic local_sel,
  input logic grant,
  input logic busy,
  input logic cnt_expire,
  input logic release_evt
);
  logic        guarding;
  logic [15:0] gcnt;

  assign guarding = busy && !echo_pass && !grant;

  // Independent strobe count over the guard window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gcnt <= '0;
    else if (!guarding)
      gcnt <= '0;
    else if (bit_stb && (gcnt < 16'(GUARD_BITS)))
      gcnt <= gcnt + 16'd1;
  end

  a_r1_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (up_d == term_d) && echo_pass && !grant && !local_sel);

  a_r2_req_blocks_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (busy && !echo_pass));

  a_r3_guard_ones: assert property (@(posedge clk) disable iff (!rst_n)
    guarding |-> up_d);

  a_r4_no_early_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (guarding && (gcnt < 16'(GUARD_BITS))) |=> !grant);

  a_r4_grant_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (guarding && (gcnt == 16'(GUARD_BITS))) |=> grant);

  a_r4_grant_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(cnt_expire));

  a_r5_local_source: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (up_d == local_d) && local_sel && !echo_pass);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && done) |=> (!grant && echo_pass));

  a_r6_release_evt: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |-> (grant && done));
endmodule

bind dchan_takeover dct_checker #(.GUARD_BITS(GUARD_BITS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_stb     (bit_stb),
  .req         (req),
  .done        (done),
  .term_d      (term_d),
  .local_d     (local_d),
  .up_d        (up_d),
  .echo_pass   (echo_pass),
  .local_sel   (local_sel),
  .grant       (grant),
  .busy        (busy),
  .cnt_expire  (cnt_expire),
  .release_evt (release_evt)
);

// File: tb/dchan_takeover_tb_top.sv
module dchan_takeover_tb_top;
  localparam int HOLD_W   = 8;
  localparam int GUARD_EX = (1500 * 16000 + 999999) / 1000000;
  localparam int STB_DIV  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic req = 1'b0;
  logic done = 1'b0;
  logic [HOLD_W-1:0] holdoff_cfg = 8'd5;
  logic term_d = 1'b1;
  logic local_d = 1'b1;
  logic up_d, echo_pass, local_sel, grant, busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dchan_takeover #(.HOLD_W(HOLD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .req(req), .done(done),
    .holdoff_cfg(holdoff_cfg), .term_d(term_d), .local_d(local_d),
    .up_d(up_d), .echo_pass(echo_pass), .local_sel(local_sel),
    .grant(grant), .busy(busy)
  );

  // Strobe generator, updated just after the rising edge.
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      #1;
      div = (div + 1) % STB_DIV;
      bit_stb = (div == 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulse req, check R2, run the guard; returns number of guard strobes.
  task automatic do_takeover(output int nstb, output int bad_ones);
    nstb = 0;
    bad_ones = 0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(busy && !echo_pass, "R2 echo blocked after req", {30'd0, busy, echo_pass}, 2);
    for (int i = 0; i < 1000 && !grant; i++) begin
      if (up_d !== 1'b1) bad_ones++;
      if (bit_stb) nstb++;
      term_d  = ~term_d;
      local_d = ~local_d;
      #0;
      @(negedge clk);
    end
  endtask

  // Pulse done, check R6, count hold strobes until busy drops.
  task automatic do_release(output int nhold);
    nhold = 0;
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    check(!grant && echo_pass, "R6 echo restored", {30'd0, grant, echo_pass}, 1);
    term_d = 1'b0; #1;
    check(up_d == 1'b0, "R6 up_d follows term_d", up_d, 0);
    term_d = 1'b1; #1;
    check(up_d == 1'b1, "R6 up_d follows term_d", up_d, 1);
    for (int i = 0; i < 2000 && busy; i++) begin
      if (grant) nhold += 1000;
      if (bit_stb) nhold++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(!busy && !grant && !local_sel && echo_pass, "R10 reset state",
          {28'd0, busy, grant, local_sel, echo_pass}, 1);
    @(negedge clk);
    term_d = 1'b0; local_d = 1'b1; #1;
    check(up_d == 1'b0 && echo_pass && !grant, "R1 idle pass 0", up_d, 0);
    term_d = 1'b1; local_d = 1'b0; #1;
    check(up_d == 1'b1 && !local_sel, "R1 idle pass 1", up_d, 1);
  endtask

  task automatic t_full_cycle;
    int n, bad, h;
    holdoff_cfg = 8'd5;
    do_takeover(n, bad);
    check(bad == 0, "R3 guard ones", bad, 0);
    check(n == GUARD_EX, "R4 guard length", n, GUARD_EX);
    local_d = 1'b0; term_d = 1'b1; #1;
    check(up_d == 1'b0 && local_sel && !echo_pass, "R5 local source 0", up_d, 0);
    local_d = 1'b1; term_d = 1'b0; #1;
    check(up_d == 1'b1, "R5 local source 1", up_d, 1);
    do_release(h);
    check(h == 5, "R7 hold-off length", h, 5);
  endtask

  task automatic t_done_ignored;
    int n, bad, h;
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check(echo_pass && !busy, "R9 done in idle ignored", {30'd0, echo_pass, busy}, 2);
    fork
      do_takeover(n, bad);
      begin
        repeat (10) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
      end
    join
    check(n == GUARD_EX, "R9 done in guard ignored", n, GUARD_EX);
    do_release(h);
  endtask

  task automatic t_holdoff_zero;
    int n, bad;
    holdoff_cfg = 8'd0;
    do_takeover(n, bad);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    check(busy && !grant, "R7 zero hold one cycle busy", busy, 1);
    @(negedge clk);
    check(!busy, "R7 zero hold idle", busy, 0);
  endtask

  task automatic t_req_held;
    int n, bad, h, wait_c;
    holdoff_cfg = 8'd4;
    do_takeover(n, bad);
    req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(grant, "R8 req while granted keeps grant", grant, 1);
    do_release(h);
    check(h == 4, "R7 hold-off blocks grant", h, 4);
    wait_c = 0;
    while (echo_pass && wait_c < 5) begin
      @(negedge clk);
      wait_c++;
    end
    check(!echo_pass && wait_c <= 1, "R8 held request served", wait_c, 1);
    for (int i = 0; i < 1000 && !grant; i++) @(negedge clk);
    check(grant, "R8 second grant", grant, 1);
    do_release(h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_cycle();
    t_done_ignored();
    t_holdoff_zero();
    t_req_held();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule